// File: doc/BRIEF.md
# Multi-depth LCD pixel unpacker

This block sits between the framebuffer fetch path and the palette / colour pipeline of an LCD controller. It accepts 32-bit framebuffer words on a valid/ready stream and emits one pixel per handshake on a second valid/ready stream. In the four packed modes (1, 2, 4 and 8 bits per pixel) each output carries a palette index. In the remaining modes (16-bit 5551, 16-bit 565, 12-bit and 32-bit) each output carries expanded 8-bit red, green and blue values. Options select byte order, pixel order within a byte, red/blue swap, and a 2-bit external mux control that reinterprets the generic 16-bit mode.

The format options are captured together with each word at the moment the word is accepted. The controller may therefore change them between words, and a word already in flight keeps its own format. A separate combinational output gives the number of framebuffer bytes per display line for the live depth and column count.

Back-pressure rules: a pixel is transferred on a cycle where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the pixel fields are held unchanged. `in_ready` is high when no word is held, or when the last pixel of the held word is leaving in the same cycle, so back-to-back words stream without a bubble.

Top module: `lcd_pixel_unpacker`

## Requirements
- R1: `bytes_per_line` equals cols/8, cols/4, cols/2, cols, cols*2 and cols*4 for depth codes 0, 1, 2, 3, {4,6,7} and 5 respectively, with the division truncating.
- R2: Depth codes 0 to 3 (1, 2, 4 and 8 bpp) output `out_is_index`=1, the pixel field zero-extended on `out_index`, and zero colour. Depth codes 4 to 7 output `out_is_index`=0, `out_index`=0 and a colour.
- R3: A word yields 32/w pixels, where w is 1, 2, 4, 8, 16 or 32. The 12-bit mode uses 16-bit containers and w=16. With both order options clear, pixel i is taken from bits [i*w+w-1 : i*w].
- R4: When the byte-order option `cfg_be_byte` is set, pixel i is taken from bits [31-i*w : 32-(i+1)*w] whatever `cfg_be_pix` holds. The byte-order option has priority.
- R5: With `cfg_be_pix` set and `cfg_be_byte` clear, bytes are still taken from the least significant byte first. Sub-byte pixels inside each byte are taken from the MSB end first. The option has no effect at 8 bpp and above.
- R6: In 5551 decoding, red is bits [4:0], green is bits [9:5] and blue is bits [14:10]. Bit 15 is ignored. Each 5-bit value c expands to {c, c[4:2]}.
- R7: In 565 decoding (depth code 6), red is bits [4:0], green is bits [10:5] and blue is bits [15:11]. The 6-bit green g expands to {g, g[5:4]}.
- R8: In depth code 4, `cfg_mux`=1 selects 5551, `cfg_mux`=3 selects 565 with the red/blue swap forced on, and `cfg_mux`=0 or 2 selects 565 with the swap following `cfg_bgr`.
- R9: In 12-bit mode, red is bits [3:0], green is bits [7:4] and blue is bits [11:8], each expanded to {c, c}. In 32-bit mode, red is bits [7:0], green is bits [15:8] and blue is bits [23:16]. Unused upper bits are ignored.
- R10: When the swap is in effect (`cfg_bgr`=1, or forced by R8), the red and blue outputs exchange values in every direct-colour mode.
- R11: The format inputs (`cfg_depth`, `cfg_bgr`, `cfg_be_byte`, `cfg_be_pix`, `cfg_mux`) are sampled with the word when it is accepted. Later changes affect only later words.
- R12: Pixels leave in order with none lost or repeated. While stalled, the output fields stay stable. `in_ready` is high whenever no pixel is pending.
- R13: While `rst_n` is low, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_depth | input | 3 | Depth code 0..7 |
| cfg_bgr | input | 1 | Swap red and blue |
| cfg_be_byte | input | 1 | Big-endian byte order, whole word MSB end first |
| cfg_be_pix | input | 1 | MSB-first sub-byte pixel order |
| cfg_mux | input | 2 | External 16-bit reinterpretation control |
| cfg_cols | input | COLS_W | Pixels per line |
| bytes_per_line | output | COLS_W+2 | Framebuffer bytes per line |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when high with in_valid |
| in_word | input | 32 | Framebuffer word |
| out_valid | output | 1 | Pixel valid |
| out_ready | input | 1 | Pixel consumer ready |
| out_is_index | output | 1 | Pixel is a palette index |
| out_index | output | 8 | Palette index |
| out_red | output | 8 | Red component |
| out_green | output | 8 | Green component |
| out_blue | output | 8 | Blue component |

## Verification
The bench aims at the pixel position arithmetic under all three order settings at every width. A wrong flip there would emit pixels of a word in reverse or nibble-scrambled order, and that shows up as the first mismatch inside a word. It sweeps the four mux values in depth code 4, where a wrong mapping would show 5551 colours where 565 is expected or a missing red/blue swap. It changes the format on every word while the output is stalled, so a design that decoded with the live format instead of the captured one would corrupt the tail of the held word. Random `out_ready` stalls catch lost or repeated pixels at word boundaries and outputs that drift during a stall.

// File: rtl/pxu_pkg.sv
package pxu_pkg;

  localparam int WORD_W = 32;
  localparam int IDX_W  = $clog2(WORD_W);

  typedef enum logic [2:0] {
    PXD_1   = 3'd0,
    PXD_2   = 3'd1,
    PXD_4   = 3'd2,
    PXD_8   = 3'd3,
    PXD_16N = 3'd4,
    PXD_32  = 3'd5,
    PXD_565 = 3'd6,
    PXD_12  = 3'd7
  } pxu_depth_e;

  typedef struct packed {
    pxu_depth_e  depth;
    logic        bgr;
    logic        be_byte;
    logic        be_pix;
    logic [1:0]  mux;
  } pxu_fmt_t;

  typedef struct packed {
    logic        is_index;
    logic [7:0]  index;
    logic [7:0]  red;
    logic [7:0]  green;
    logic [7:0]  blue;
  } pxu_pixel_t;

  // container width in bits for a depth code
  function automatic logic [5:0] pxu_width(pxu_depth_e d);
    case (d)
      PXD_1:   return 6'd1;
      PXD_2:   return 6'd2;
      PXD_4:   return 6'd4;
      PXD_8:   return 6'd8;
      PXD_32:  return 6'd32;
      default: return 6'd16;
    endcase
  endfunction

  // index of the final pixel within one word
  function automatic logic [IDX_W-1:0] pxu_last_idx(pxu_depth_e d);
    case (d)
      PXD_1:   return IDX_W'(31);
      PXD_2:   return IDX_W'(15);
      PXD_4:   return IDX_W'(7);
      PXD_8:   return IDX_W'(3);
      PXD_32:  return IDX_W'(0);
      default: return IDX_W'(1);
    endcase
  endfunction

  function automatic logic [7:0] pxu_grow5(logic [4:0] c);
    return {c, c[4:2]};
  endfunction

  function automatic logic [7:0] pxu_grow6(logic [5:0] c);
    return {c, c[5:4]};
  endfunction

  function automatic logic [7:0] pxu_grow4(logic [3:0] c);
    return {c, c};
  endfunction

endpackage

// File: rtl/pxu_word_slot.sv
module pxu_word_slot
  import pxu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  input  pxu_fmt_t          in_fmt,
  output logic              in_ready,
  input  logic              out_ready,
  output logic              slot_full,
  output logic [WORD_W-1:0] slot_word,
  output pxu_fmt_t          slot_fmt,
  output logic [IDX_W-1:0]  slot_idx
);

  logic last_px;
  logic load;
  logic take;

  assign last_px  = (slot_idx == pxu_last_idx(slot_fmt.depth));
  assign in_ready = !slot_full || (out_ready && last_px);
  assign load     = in_valid && in_ready;
  assign take     = slot_full && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_full <= 1'b0;
      slot_word <= '0;
      slot_fmt  <= '0;
      slot_idx  <= '0;
    end else if (load) begin
      slot_full <= 1'b1;
      slot_word <= in_word;
      slot_fmt  <= in_fmt;
      slot_idx  <= '0;
    end else if (take) begin
      if (last_px) begin
        slot_full <= 1'b0;
      end else begin
        slot_idx <= slot_idx + 1'b1;
      end
    end
  end

endmodule

// File: rtl/pxu_pixel_pick.sv
module pxu_pixel_pick
  import pxu_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  pxu_fmt_t          fmt,
  input  logic [IDX_W-1:0]  idx,
  output logic [23:0]       field
);

  logic [5:0]       w;
  logic [10:0]      prod;
  logic [IDX_W-1:0] pos;
  logic [IDX_W-1:0] flip;
  logic [IDX_W-1:0] shamt;
  logic [WORD_W-1:0] keep;

  always_comb begin
    w    = pxu_width(fmt.depth);
    prod = 11'(idx) * 11'(w);
    pos  = prod[IDX_W-1:0];
    // position flips: whole word for byte order, within a byte for pixel order
    if (fmt.be_byte) begin
      flip = IDX_W'(6'd32 - w);
    end else if (fmt.be_pix && (w < 6'd8)) begin
      flip = IDX_W'(6'd8 - w);
    end else begin
      flip = '0;
    end
    shamt = pos ^ flip;
    keep  = (w == 6'd32) ? '1 : ((WORD_W'(1) << w) - WORD_W'(1));
    field = 24'((word >> shamt) & keep);
  end

endmodule

// File: rtl/pxu_color_decode.sv
module pxu_color_decode
  import pxu_pkg::*;
(
  input  logic [23:0] field,
  input  pxu_fmt_t    fmt,
  output pxu_pixel_t  pixel
);

  logic       swap;
  logic [7:0] r;
  logic [7:0] g;
  logic [7:0] b;
  logic       use5551;

  always_comb begin
    pixel   = '0;
    swap    = fmt.bgr;
    r       = '0;
    g       = '0;
    b       = '0;
    use5551 = 1'b0;
    case (fmt.depth)
      PXD_1, PXD_2, PXD_4, PXD_8: begin
        pixel.is_index = 1'b1;
        pixel.index    = field[7:0];
      end
      PXD_32: begin
        r = field[7:0];
        g = field[15:8];
        b = field[23:16];
      end
      PXD_12: begin
        r = pxu_grow4(field[3:0]);
        g = pxu_grow4(field[7:4]);
        b = pxu_grow4(field[11:8]);
      end
      default: begin
        if (fmt.depth == PXD_16N) begin
          if (fmt.mux == 2'd1) use5551 = 1'b1;
          if (fmt.mux == 2'd3) swap    = 1'b1;
        end
        if (use5551) begin
          r = pxu_grow5(field[4:0]);
          g = pxu_grow5(field[9:5]);
          b = pxu_grow5(field[14:10]);
        end else begin
          r = pxu_grow5(field[4:0]);
          g = pxu_grow6(field[10:5]);
          b = pxu_grow5(field[15:11]);
        end
      end
    endcase
    if (!pixel.is_index) begin
      pixel.red   = swap ? b : r;
      pixel.green = g;
      pixel.blue  = swap ? r : b;
    end
  end

endmodule

// File: rtl/pxu_line_bytes.sv
module pxu_line_bytes
  import pxu_pkg::*;
#(
  parameter int COLS_W = 12,
  localparam int BPL_W = COLS_W + 2
) (
  input  logic [COLS_W-1:0] cols,
  input  pxu_depth_e        depth,
  output logic [BPL_W-1:0]  bytes
);

  logic [BPL_W-1:0] wide;

  assign wide = BPL_W'(cols);

  always_comb begin
    case (depth)
      PXD_1:   bytes = wide >> 3;
      PXD_2:   bytes = wide >> 2;
      PXD_4:   bytes = wide >> 1;
      PXD_8:   bytes = wide;
      PXD_32:  bytes = wide << 2;
      default: bytes = wide << 1;
    endcase
  end

endmodule

// File: rtl/lcd_pixel_unpacker.sv
module lcd_pixel_unpacker
  import pxu_pkg::*;
#(
  parameter int COLS_W = 12,
  localparam int BPL_W = COLS_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cfg_depth,
  input  logic              cfg_bgr,
  input  logic              cfg_be_byte,
  input  logic              cfg_be_pix,
  input  logic [1:0]        cfg_mux,
  input  logic [COLS_W-1:0] cfg_cols,
  output logic [BPL_W-1:0]  bytes_per_line,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [31:0]       in_word,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_is_index,
  output logic [7:0]        out_index,
  output logic [7:0]        out_red,
  output logic [7:0]        out_green,
  output logic [7:0]        out_blue
);

  pxu_fmt_t          live_fmt;
  pxu_fmt_t          slot_fmt;
  logic [WORD_W-1:0] slot_word;
  logic [IDX_W-1:0]  slot_idx;
  logic [23:0]       field;
  pxu_pixel_t        pixel;

  always_comb begin
    live_fmt.depth   = pxu_depth_e'(cfg_depth);
    live_fmt.bgr     = cfg_bgr;
    live_fmt.be_byte = cfg_be_byte;
    live_fmt.be_pix  = cfg_be_pix;
    live_fmt.mux     = cfg_mux;
  end

  pxu_word_slot u_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_word   (in_word),
    .in_fmt    (live_fmt),
    .in_ready  (in_ready),
    .out_ready (out_ready),
    .slot_full (out_valid),
    .slot_word (slot_word),
    .slot_fmt  (slot_fmt),
    .slot_idx  (slot_idx)
  );

  pxu_pixel_pick u_pick (
    .word  (slot_word),
    .fmt   (slot_fmt),
    .idx   (slot_idx),
    .field (field)
  );

  pxu_color_decode u_decode (
    .field (field),
    .fmt   (slot_fmt),
    .pixel (pixel)
  );

  pxu_line_bytes #(.COLS_W(COLS_W)) u_bpl (
    .cols  (cfg_cols),
    .depth (pxu_depth_e'(cfg_depth)),
    .bytes (bytes_per_line)
  );

  assign out_is_index = pixel.is_index;
  assign out_index    = pixel.index;
  assign out_red      = pixel.red;
  assign out_green    = pixel.green;
  assign out_blue     = pixel.blue;

endmodule

// File: rtl/pxu_checker.sv
module pxu_checker #(
  parameter int COLS_W = 12,
  localparam int BPL_W = COLS_W + 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        cfg_depth,
  input logic [COLS_W-1:0] cfg_cols,
  input logic [BPL_W-1:0]  bytes_per_line,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_is_index,
  input logic [7:0]        out_index,
  input logic [7:0]        out_red,
  input logic [7:0]        out_green,
  input logic [7:0]        out_blue
);

  AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_is_index) && $stable(out_index)
      && $stable(out_red) && $stable(out_green) && $stable(out_blue))); // R12

  AST_EMPTY_TAKES_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready); // R12

  AST_INDEX_HAS_NO_COLOUR: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_is_index) |-> ({out_red, out_green, out_blue} == 24'd0)); // R2

  AST_COLOUR_HAS_NO_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_is_index) |-> (out_index == 8'd0)); // R2

  AST_BPL_BYTE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_depth == 3'd3) |-> (bytes_per_line == BPL_W'(cfg_cols))); // R1

endmodule

bind lcd_pixel_unpacker pxu_checker #(.COLS_W(COLS_W)) u_pxu_checker (
  .clk            (clk),
  .rst_n          (rst_n),
  .cfg_depth      (cfg_depth),
  .cfg_cols       (cfg_cols),
  .bytes_per_line (bytes_per_line),
  .in_ready       (in_ready),
  .out_valid      (out_valid),
  .out_ready      (out_ready),
  .out_is_index   (out_is_index),
  .out_index      (out_index),
  .out_red        (out_red),
  .out_green      (out_green),
  .out_blue       (out_blue)
);

// File: tb/tb_lcd_pixel_unpacker.sv
module tb_lcd_pixel_unpacker;

  localparam int COLS_W = 12;
  localparam int BPL_W  = COLS_W + 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [2:0]        cfg_depth = '0;
  logic              cfg_bgr = 1'b0;
  logic              cfg_be_byte = 1'b0;
  logic              cfg_be_pix = 1'b0;
  logic [1:0]        cfg_mux = '0;
  logic [COLS_W-1:0] cfg_cols = '0;
  logic [BPL_W-1:0]  bytes_per_line;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [31:0]       in_word = '0;
  logic              out_valid;
  logic              out_ready = 1'b0;
  logic              out_is_index;
  logic [7:0]        out_index;
  logic [7:0]        out_red;
  logic [7:0]        out_green;
  logic [7:0]        out_blue;

  int n_cmp = 0;
  int n_bad = 0;

  typedef struct {
    logic [31:0] word;
    logic [7:0]  cfg; // {depth[2:0], bgr, be_byte, be_pix, mux[1:0]}
  } item_t;

  item_t       in_q[$];
  logic [32:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  lcd_pixel_unpacker #(.COLS_W(COLS_W)) dut (
    .clk (clk), .rst_n (rst_n),
    .cfg_depth (cfg_depth), .cfg_bgr (cfg_bgr), .cfg_be_byte (cfg_be_byte),
    .cfg_be_pix (cfg_be_pix), .cfg_mux (cfg_mux), .cfg_cols (cfg_cols),
    .bytes_per_line (bytes_per_line),
    .in_valid (in_valid), .in_ready (in_ready), .in_word (in_word),
    .out_valid (out_valid), .out_ready (out_ready),
    .out_is_index (out_is_index), .out_index (out_index),
    .out_red (out_red), .out_green (out_green), .out_blue (out_blue)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  function automatic int bits_of(input logic [2:0] d);
    case (d)
      3'd0: return 1;
      3'd1: return 2;
      3'd2: return 4;
      3'd3: return 8;
      3'd5: return 32;
      default: return 16;
    endcase
  endfunction

  // R3 / R4 / R5 position rules
  function automatic logic [31:0] extract(input logic [31:0] word, input logic [7:0] cfg, input int i);
    int w, sh, k;
    logic [63:0] m;
    w = bits_of(cfg[7:5]);
    if (cfg[3]) sh = 32 - (i + 1) * w;
    else if (cfg[2] && w < 8) begin
      k  = 8 / w;
      sh = (i / k) * 8 + 8 - ((i % k) + 1) * w;
    end else sh = i * w;
    m = (64'd1 << w) - 64'd1;
    return 32'((64'(word) >> sh) & m);
  endfunction

  function automatic logic [32:0] model(input logic [31:0] f, input logic [7:0] cfg);
    logic [2:0] d;
    logic [7:0] r, g, b, t;
    logic swap;
    d = cfg[7:5];
    swap = cfg[4];
    if (d < 3'd4) return {1'b1, f[7:0], 24'd0};
    case (d)
      3'd5: begin r = f[7:0]; g = f[15:8]; b = f[23:16]; end
      3'd7: begin r = {f[3:0], f[3:0]}; g = {f[7:4], f[7:4]}; b = {f[11:8], f[11:8]}; end
      default: begin
        if (d == 3'd4 && cfg[1:0] == 2'd1) begin
          r = {f[4:0], f[4:2]}; g = {f[9:5], f[9:7]}; b = {f[14:10], f[14:12]};
        end else begin
          if (d == 3'd4 && cfg[1:0] == 2'd3) swap = 1'b1;
          r = {f[4:0], f[4:2]}; g = {f[10:5], f[10:9]}; b = {f[15:11], f[15:13]};
        end
      end
    endcase
    if (swap) begin t = r; r = b; b = t; end
    return {1'b0, 8'd0, r, g, b};
  endfunction

  function automatic string tag_of(input logic [7:0] cfg);
    string o, f;
    o = cfg[3] ? "R4" : (cfg[2] ? "R5" : "R3");
    case (cfg[7:5])
      3'd0, 3'd1, 3'd2, 3'd3: f = "R2";
      3'd5, 3'd7: f = "R9";
      3'd6: f = "R7";
      default: f = (cfg[1:0] == 2'd1) ? "R6" : "R8";
    endcase
    if (cfg[7:5] >= 3'd4 && (cfg[4] || (cfg[7:5] == 3'd4 && cfg[1:0] == 2'd3))) f = {f, "/R10"};
    return {o, " ", f, " per-word format R11"};
  endfunction

  task automatic push(input logic [31:0] word, input logic [7:0] cfg);
    item_t it;
    it.word = word;
    it.cfg  = cfg;
    in_q.push_back(it);
  endtask

  task automatic run(input int ready_pct);
    int guard = 0;
    bit stalled = 0;
    logic [32:0] held = '0, cur;
    while ((in_q.size() > 0 || exp_q.size() > 0) && guard < 60000) begin
      @(negedge clk);
      out_ready = (($urandom % 100) < ready_pct);
      if (in_q.size() > 0) begin
        in_valid = 1'b1;
        in_word  = in_q[0].word;
        {cfg_depth, cfg_bgr, cfg_be_byte, cfg_be_pix, cfg_mux} = in_q[0].cfg;
      end else begin
        in_valid = 1'b0;
        // format changes on an idle input must not touch the held word (R11)
        {cfg_depth, cfg_bgr, cfg_be_byte, cfg_be_pix, cfg_mux} = 8'($urandom);
      end
      #1;
      cur = {out_is_index, out_index, out_red, out_green, out_blue};
      if (stalled) check(out_valid && cur == held, "R12 stall hold", 64'(cur), 64'(held));
      stalled = out_valid && !out_ready;
      held = cur;
      if (!out_valid) check(in_ready == 1'b1, "R12 empty ready", 64'(in_ready), 64'd1);
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) check(1'b0, "R12 extra pixel", 64'(cur), 64'd0);
        else begin
          check(cur == exp_q[0], tag_q[0], 64'(cur), 64'(exp_q[0]));
          void'(exp_q.pop_front());
          void'(tag_q.pop_front());
        end
      end
      if (in_valid && in_ready) begin
        for (int i = 0; i < 32 / bits_of(in_q[0].cfg[7:5]); i++) begin
          exp_q.push_back(model(extract(in_q[0].word, in_q[0].cfg, i), in_q[0].cfg));
          tag_q.push_back(tag_of(in_q[0].cfg));
        end
        void'(in_q.pop_front());
      end
      guard++;
    end
    @(negedge clk);
    in_valid  = 1'b0;
    out_ready = 1'b0;
    if (guard >= 60000) check(1'b0, "R12 stream hung", 64'(exp_q.size()), 64'd0);
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    // R13 reset state
    #3;
    check(out_valid == 1'b0, "R13 out_valid in reset", 64'(out_valid), 64'd0);
    check(in_ready == 1'b1, "R13 in_ready in reset", 64'(in_ready), 64'd1);
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 bytes per line, all depths, including truncation
    for (int c = 0; c < 3; c++) begin
      logic [COLS_W-1:0] cols;
      cols = (c == 0) ? 12'd640 : ((c == 1) ? 12'd4095 : 12'd7);
      for (int d = 0; d < 8; d++) begin
        logic [BPL_W-1:0] e;
        @(negedge clk);
        cfg_cols  = cols;
        cfg_depth = 3'(d);
        #1;
        case (d)
          0: e = BPL_W'(cols / 8);
          1: e = BPL_W'(cols / 4);
          2: e = BPL_W'(cols / 2);
          3: e = BPL_W'(cols);
          5: e = BPL_W'(cols) * 4;
          default: e = BPL_W'(cols) * 2;
        endcase
        check(bytes_per_line == e, "R1 bytes per line", 64'(bytes_per_line), 64'(e));
      end
    end

    // directed corners
    push(32'h0000_0005, {3'd0, 5'b00000});       // R3 1bpp LSB first
    push(32'h8000_0001, {3'd0, 5'b00100});       // R5 1bpp MSB first per byte
    push(32'h1B2C_3D4E, {3'd1, 5'b00100});       // R5 2bpp
    push(32'h1122_3344, {3'd3, 5'b01100});       // R4 8bpp, be_pix ignored
    push(32'hA5C3_0F96, {3'd2, 5'b01000});       // R4 4bpp
    push(32'h1234_5678, {3'd3, 5'b00100});       // R5 no effect at 8bpp
    push(32'hFFFF_8000, {3'd4, 5'b00001});       // R6 bit 15 ignored
    push(32'h7C1F_03E0, {3'd4, 5'b00011});       // R8 mux 3 forced swap
    push(32'h7C1F_03E0, {3'd4, 5'b00000});       // R8 mux 0
    push(32'h7C1F_03E0, {3'd4, 5'b10010});       // R8 mux 2 with bgr
    push(32'hF800_07E0, {3'd6, 5'b10000});       // R7 / R10
    push(32'hFABC_0123, {3'd7, 5'b00000});       // R9 12bpp
    push(32'hEE11_2233, {3'd5, 5'b10000});       // R9 / R10 32bpp
    push(32'h0102_0304, {3'd6, 5'b01000});       // R4 16bpp
    run(100);

    // same corners under heavy back-pressure (R11, R12)
    push(32'hDEAD_BEEF, {3'd0, 5'b00100});
    push(32'hDEAD_BEEF, {3'd4, 5'b00001});
    push(32'hDEAD_BEEF, {3'd2, 5'b01000});
    run(30);

    // constrained random: every format, every order, random stalls
    for (int n = 0; n < 300; n++) push($urandom, 8'($urandom));
    run(60);
    for (int n = 0; n < 100; n++) push($urandom, 8'($urandom));
    run(95);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule